// File: doc/BRIEF.md
# Address Trace Dictionary Compressor

This block shrinks a stream of bus addresses before it is written to trace storage. Every clock it may receive one address, marked by a valid flag. Addresses that simply continue a linear run are discarded. Only the first address of a run (the target) and the last address of a run (the branch) are kept.

Each kept address is searched for in a small associative dictionary. On a hit the block emits the entry number. If the hit falls on the entry that follows the previous hit, it emits a bare continuous-hit marker instead. On a miss the block emits the address with its leading 4-bit slices removed, where those slices match the previous miss. It then stores the address in the dictionary, replacing entries oldest first.

One record per cycle leaves a register, one cycle after the address was picked. A record has a 2-bit kind, a payload and a size value, and a downstream packer builds headers from them.

The sequence filter is a three-state machine:
- `ST_EMPTY`: no address seen since reset.
- `ST_HEAD`: the last valid address was kept. A single pending target may be waiting.
- `ST_RUN`: at least two addresses of a linear run have been seen.

Its transitions are:
- `EMPTY->HEAD` on the first valid address.
- `HEAD->RUN` on a sequential address.
- `HEAD->HEAD` on a non-sequential address.
- `RUN->RUN` on a sequential address.
- `RUN->HEAD` on a non-sequential address. This emits the branch and parks the new target as pending.

Top module: `addr_trace_compressor`

## Requirements
- R1: A synchronous reset makes the next record kind 11 with payload 0 and size 0. It also empties every dictionary entry, returns the fill position to entry 0, sets the previous-miss register to 0 and returns the filter to `ST_EMPTY`.
- R2: Record kinds are encoded as 00 index hit, 01 continuous hit, 10 sliced miss and 11 none. A kind-11 record always has payload 0 and size 0. An address picked in cycle t appears on the outputs after the clock edge that ends cycle t.
- R3: A valid address equal to the last valid input plus STRIDE (4) is dropped. Cycles with the valid flag low neither drop nor reset this tracking.
- R4: A run of two or more addresses ended by a non-sequential address produces a record for the run's last address first. The new target's record follows in the next cycle. A pending target is always emitted before any newer kept address.
- R5: A non-sequential address that follows a kept address is kept itself. An isolated address yields exactly one record.
- R6: A kept address found in dictionary entry i yields kind 00 with payload i (zero-extended) and size 0.
- R7: A hit on entry (j+1) mod DEPTH, where the previous kept address hit entry j, yields kind 01 with payload 0 and size 0.
- R8: A miss writes the address at the fill position, which then advances. After DEPTH misses the next miss overwrites entry 0, so the oldest address is evicted.
- R9: A miss yields kind 10. Size holds the number of identical 4-bit slices, counted from bit 31 downward against the previous miss address, stopping at the first difference and capped at 7. Payload holds the address with those leading slices cleared.
- R10: Only misses update the previous-miss register. Hits leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address on in_addr is valid this cycle |
| in_addr | input | 32 | Bus address |
| rec_type | output | 2 | Record kind (00 hit, 01 continuous hit, 10 miss, 11 none) |
| rec_payload | output | 32 | Entry index or remaining address slices |
| rec_size | output | 3 | Count of leading slices elided on a miss, 0 otherwise |

## Verification
Several properties are checked on every cycle:
- Idle records are clean.
- Hit indices stay inside the dictionary.
- A continuous-hit marker only ever follows a hit.
- Two sequential inputs in a row produce no record on the next edge.
- A miss payload never carries bits above its unelided slices.

Other behaviour can only be shown by the bench's scenarios:
- Branch-before-target ordering and the pending target.
- FIFO eviction at the wrap of the fill position.
- The wrap of the continuous-hit test from entry 7 to entry 0.
- The exact slice counts.
- That a hit leaves the previous-miss register unchanged.

// File: rtl/atc_pkg.sv
package atc_pkg;

    typedef enum logic [1:0] {
        REC_HIT  = 2'b00,
        REC_CONT = 2'b01,
        REC_MISS = 2'b10,
        REC_NONE = 2'b11
    } rec_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_HEAD  = 2'b01,
        ST_RUN   = 2'b10
    } flt_state_e;

endpackage

// File: rtl/atc_seq_filter.sv
module atc_seq_filter
    import atc_pkg::*;
#(
    parameter int AW     = 32,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    output logic          sel_valid,
    output logic [AW-1:0] sel_addr
);

    flt_state_e    state, state_nxt;
    logic [AW-1:0] last_addr;
    logic          pend_vld, pend_vld_nxt;
    logic [AW-1:0] pend_addr, pend_addr_nxt;
    logic          is_seq;

    assign is_seq = (in_addr == last_addr + AW'(STRIDE));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_EMPTY;
            last_addr <= '0;
            pend_vld  <= 1'b0;
            pend_addr <= '0;
        end else begin
            state     <= state_nxt;
            pend_vld  <= pend_vld_nxt;
            pend_addr <= pend_addr_nxt;
            if (in_valid) begin
                last_addr <= in_addr;
            end
        end
    end

    // next state and selected address
    always_comb begin
        state_nxt     = state;
        pend_vld_nxt  = 1'b0;
        pend_addr_nxt = pend_addr;
        sel_valid     = 1'b0;
        sel_addr      = '0;
        unique case (state)
            ST_EMPTY: begin
                if (in_valid) begin
                    sel_valid = 1'b1;
                    sel_addr  = in_addr;
                    state_nxt = ST_HEAD;
                end
            end
            ST_HEAD: begin
                if (pend_vld) begin
                    sel_valid = 1'b1;
                    sel_addr  = pend_addr;
                end
                if (in_valid) begin
                    if (is_seq) begin
                        state_nxt = ST_RUN;
                    end else if (pend_vld) begin
                        pend_vld_nxt  = 1'b1;
                        pend_addr_nxt = in_addr;
                    end else begin
                        sel_valid = 1'b1;
                        sel_addr  = in_addr;
                    end
                end
            end
            ST_RUN: begin
                if (in_valid && !is_seq) begin
                    sel_valid     = 1'b1;
                    sel_addr      = last_addr;
                    pend_vld_nxt  = 1'b1;
                    pend_addr_nxt = in_addr;
                    state_nxt     = ST_HEAD;
                end
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/atc_dict.sv
module atc_dict #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            look_valid,
    input  logic [AW-1:0]   look_addr,
    output logic            hit,
    output logic            cont,
    output logic [IDXW-1:0] hit_idx
);

    logic [AW-1:0]   ent [DEPTH];
    logic [DEPTH-1:0] ent_vld;
    logic [DEPTH-1:0] match;
    logic [IDXW-1:0] wr_ptr;
    logic            last_hit_vld;
    logic [IDXW-1:0] last_hit_idx;

    function automatic logic [IDXW-1:0] next_idx(input logic [IDXW-1:0] idx);
        return (idx == IDXW'(DEPTH - 1)) ? '0 : idx + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent[g] == look_addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit_idx = IDXW'(i);
            end
        end
    end

    assign hit  = look_valid && (|match);
    assign cont = hit && last_hit_vld && (hit_idx == next_idx(last_hit_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
            ent_vld      <= '0;
            wr_ptr       <= '0;
            last_hit_vld <= 1'b0;
            last_hit_idx <= '0;
        end else if (look_valid) begin
            if (hit) begin
                last_hit_vld <= 1'b1;
                last_hit_idx <= hit_idx;
            end else begin
                ent[wr_ptr]     <= look_addr;
                ent_vld[wr_ptr] <= 1'b1;
                wr_ptr          <= next_idx(wr_ptr);
                last_hit_vld    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/atc_slicer.sv
module atc_slicer #(
    parameter int AW      = 32,
    parameter int SLICE_W = 4,
    localparam int NSLICE = AW / SLICE_W,
    localparam int SZW    = $clog2(NSLICE)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           miss_valid,
    input  logic [AW-1:0]  miss_addr,
    output logic [SZW-1:0] same_cnt,
    output logic [AW-1:0]  low_part
);

    logic [AW-1:0] prev_miss;
    logic [AW-1:0] keep;
    logic          still;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_miss <= '0;
        end else if (miss_valid) begin
            prev_miss <= miss_addr;
        end
    end

    // count identical leading slices, at most NSLICE-1
    always_comb begin
        same_cnt = '0;
        still    = 1'b1;
        for (int i = NSLICE - 1; i > 0; i--) begin
            if (still && (miss_addr[i*SLICE_W +: SLICE_W] == prev_miss[i*SLICE_W +: SLICE_W])) begin
                same_cnt = same_cnt + 1'b1;
            end else begin
                still = 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NSLICE; i++) begin
            keep[i*SLICE_W +: SLICE_W] = (i < NSLICE - int'(same_cnt)) ? {SLICE_W{1'b1}} : {SLICE_W{1'b0}};
        end
    end

    assign low_part = miss_addr & keep;

endmodule

// File: rtl/addr_trace_compressor.sv
module addr_trace_compressor
    import atc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int STRIDE  = 4,
    parameter int DEPTH   = 8,
    parameter int SLICE_W = 4,
    localparam int NSLICE = AW / SLICE_W,
    localparam int SZW    = $clog2(NSLICE),
    localparam int IDXW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [AW-1:0]  in_addr,
    output logic [1:0]     rec_type,
    output logic [AW-1:0]  rec_payload,
    output logic [SZW-1:0] rec_size
);

    logic            sel_valid;
    logic [AW-1:0]   sel_addr;
    logic            hit, cont;
    logic [IDXW-1:0] hit_idx;
    logic [SZW-1:0]  same_cnt;
    logic [AW-1:0]   low_part;

    atc_seq_filter #(.AW(AW), .STRIDE(STRIDE)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .sel_valid (sel_valid),
        .sel_addr  (sel_addr)
    );

    atc_dict #(.AW(AW), .DEPTH(DEPTH)) u_dict (
        .clk        (clk),
        .rst        (rst),
        .look_valid (sel_valid),
        .look_addr  (sel_addr),
        .hit        (hit),
        .cont       (cont),
        .hit_idx    (hit_idx)
    );

    atc_slicer #(.AW(AW), .SLICE_W(SLICE_W)) u_slicer (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (sel_valid && !hit),
        .miss_addr  (sel_addr),
        .same_cnt   (same_cnt),
        .low_part   (low_part)
    );

    always_ff @(posedge clk) begin
        if (rst || !sel_valid) begin
            rec_type    <= REC_NONE;
            rec_payload <= '0;
            rec_size    <= '0;
        end else if (hit && cont) begin
            rec_type    <= REC_CONT;
            rec_payload <= '0;
            rec_size    <= '0;
        end else if (hit) begin
            rec_type    <= REC_HIT;
            rec_payload <= AW'(hit_idx);
            rec_size    <= '0;
        end else begin
            rec_type    <= REC_MISS;
            rec_payload <= low_part;
            rec_size    <= same_cnt;
        end
    end

endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
    parameter int AW      = 32,
    parameter int STRIDE  = 4,
    parameter int DEPTH   = 8,
    parameter int SLICE_W = 4,
    localparam int NSLICE = AW / SLICE_W,
    localparam int SZW    = $clog2(NSLICE)
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [AW-1:0]  in_addr,
    input logic [1:0]     rec_type,
    input logic [AW-1:0]  rec_payload,
    input logic [SZW-1:0] rec_size
);

    logic          seen;
    logic [AW-1:0] last_in;
    logic          seq_prev;
    logic          seq_now;
    logic          last_was_hit;

    assign seq_now = in_valid && seen && (in_addr == last_in + AW'(STRIDE));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen         <= 1'b0;
            last_in      <= '0;
            seq_prev     <= 1'b0;
            last_was_hit <= 1'b0;
        end else begin
            if (in_valid) begin
                seen     <= 1'b1;
                last_in  <= in_addr;
                seq_prev <= seq_now;
            end
            if (rec_type != 2'b11) begin
                last_was_hit <= (rec_type == 2'b00) || (rec_type == 2'b01);
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (rec_type == 2'b11 && rec_payload == '0 && rec_size == '0));

    assert_none_clean_R2: assert property (@(posedge clk) disable iff (rst)
        (rec_type == 2'b11) |-> (rec_payload == '0 && rec_size == '0));

    assert_seq_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_now && seq_prev) |=> (rec_type == 2'b11));

    assert_hit_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        (rec_type == 2'b00) |-> (rec_payload < AW'(DEPTH) && rec_size == '0));

    assert_cont_after_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (rec_type == 2'b01) |-> (last_was_hit && rec_payload == '0 && rec_size == '0));

    assert_miss_slices_R9: assert property (@(posedge clk) disable iff (rst)
        (rec_type == 2'b10) |-> (int'(rec_size) <= NSLICE - 1 &&
            (rec_payload >> (SLICE_W * (NSLICE - int'(rec_size)))) == '0));

endmodule

bind addr_trace_compressor atc_checker #(
    .AW(AW), .STRIDE(STRIDE), .DEPTH(DEPTH), .SLICE_W(SLICE_W)
) u_atc_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_addr     (in_addr),
    .rec_type    (rec_type),
    .rec_payload (rec_payload),
    .rec_size    (rec_size)
);

// File: tb/addr_trace_compressor_tb.sv
`timescale 1ns/1ps
module addr_trace_compressor_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [1:0]  rec_type;
    logic [31:0] rec_payload;
    logic [2:0]  rec_size;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    addr_trace_compressor u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .rec_type(rec_type), .rec_payload(rec_payload), .rec_size(rec_size)
    );

    localparam logic [1:0] K_HIT = 2'b00, K_CONT = 2'b01, K_MISS = 2'b10, K_NONE = 2'b11;

    // {valid, addr, kind, payload, size}; expected record after the same edge
    localparam int NV = 19;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 32'h0000_1000, K_MISS, 32'h0000_1000, 3'd4}, // R5 R9 first target
        {1'b1, 32'h0000_1004, K_NONE, 32'h0,         3'd0}, // R3
        {1'b1, 32'h0000_1008, K_NONE, 32'h0,         3'd0}, // R3
        {1'b1, 32'h0000_2000, K_MISS, 32'h0000_0008, 3'd7}, // R4 branch first
        {1'b0, 32'h0,         K_MISS, 32'h0000_2000, 3'd4}, // R4 target next
        {1'b1, 32'h0000_2004, K_NONE, 32'h0,         3'd0}, // R3
        {1'b1, 32'h0000_1000, K_MISS, 32'h0000_0004, 3'd7}, // R4 R9
        {1'b1, 32'h0000_1004, K_HIT,  32'h0,         3'd0}, // R6 pending hits entry 0
        {1'b1, 32'h0000_1008, K_NONE, 32'h0,         3'd0}, // R3
        {1'b1, 32'h0000_2000, K_CONT, 32'h0,         3'd0}, // R7 entry 1 after 0
        {1'b1, 32'h0000_3000, K_CONT, 32'h0,         3'd0}, // R4 R7 pending before newer
        {1'b0, 32'h0,         K_MISS, 32'h0000_3000, 3'd4}, // R8 R9
        {1'b1, 32'h0000_2004, K_HIT,  32'h0000_0003, 3'd0}, // R6 R7 miss breaks chain
        {1'b1, 32'h0000_2000, K_HIT,  32'h0000_0002, 3'd0}, // R5 R6
        {1'b0, 32'h0,         K_NONE, 32'h0,         3'd0}, // R2
        {1'b1, 32'h0000_2004, K_NONE, 32'h0,         3'd0}, // R3 across idle gap
        {1'b1, 32'h0000_1000, K_CONT, 32'h0,         3'd0}, // R4 R7
        {1'b0, 32'h0,         K_HIT,  32'h0,         3'd0}, // R6
        {1'b1, 32'h0000_3010, K_MISS, 32'h0000_0010, 3'd6}  // R10 compared with last miss
    };

    task automatic check(input string req, input logic [1:0] et, input logic [31:0] ep, input logic [2:0] es);
        checks++;
        if (rec_type !== et || rec_payload !== ep || rec_size !== es) begin
            failures++;
            $display("FAIL %s: got kind=%b payload=%h size=%0d, expected kind=%b payload=%h size=%0d",
                     req, rec_type, rec_payload, rec_size, et, ep, es);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a);
        @(negedge clk);
        in_valid = v;
        in_addr  = a;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset idle", K_NONE, 32'h0, 3'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] wa(input int k);
        return 32'h0001_0000 + 32'(k) * 32'h100;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][69], VEC[i][68:37]);
            check($sformatf("R2 R4 R6 R7 R9 table step %0d", i), VEC[i][36:35], VEC[i][34:3], VEC[i][2:0]);
        end

        // R1: reset empties dictionary (0x1000 was stored) and previous miss
        do_reset();
        step(1'b1, 32'h0000_1000);
        check("R1 dictionary cleared", K_MISS, 32'h0000_1000, 3'd4);

        // R8 wrap and R7 wrap
        do_reset();
        step(1'b1, wa(0));
        check("R9 first miss after reset", K_MISS, 32'h0001_0000, 3'd3);
        for (int k = 1; k <= 8; k++) begin
            step(1'b1, wa(k));
            check($sformatf("R8 R9 fill miss %0d", k), K_MISS, 32'(k) << 8, 3'd5);
        end
        step(1'b1, wa(8));
        check("R8 wrapped into entry 0", K_HIT, 32'd0, 3'd0);
        step(1'b1, wa(2));
        check("R6 hit entry 2", K_HIT, 32'd2, 3'd0);
        step(1'b1, wa(3));
        check("R7 continuous hit", K_CONT, 32'd0, 3'd0);
        step(1'b1, wa(7));
        check("R6 hit entry 7", K_HIT, 32'd7, 3'd0);
        step(1'b1, wa(8));
        check("R7 continuous hit wraps 7 to 0", K_CONT, 32'd0, 3'd0);
        step(1'b1, wa(0));
        check("R8 R10 evicted address misses", K_MISS, 32'd0, 3'd5);
        step(1'b0, 32'h0);
        check("R2 idle after miss", K_NONE, 32'h0, 3'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule